// File: doc/BRIEF.md
# Write-Policy Cache Controller

This block sits between a processor's request port and a simple memory bus. It keeps a small direct-mapped cache of 16-byte lines in register arrays. A runtime input chooses how stores are handled. In write-back mode, stores stay in the cache until their line is evicted. In write-through mode, every store also goes out on the bus. Addresses with the top address bit set bypass the cache and become single bus accesses of the requested size.

The processor raises `cpu_req` with an address, a size, a store flag and an instruction-fetch flag. It holds these until `cpu_ready` pulses for one cycle. The bus side is a request/acknowledge port that carries 32-bit data. Each beat is held until `bus_ack` is seen. A line fill is always four longword reads. A dirty victim is saved when the miss begins. It is written back as four longword writes only after the new line has been filled and any pending store has been merged into it.

Top module: `wpc_cache`

## Requirements
- R1: A cacheable read miss issues exactly four 32-bit bus reads, with enables 1111, at line offsets 0x0, 0x4, 0x8 and 0xC in that order. This happens whatever the access size or fetch flag.
- R2: `cpu_ready` is a single-cycle pulse that ends each request. A read hit completes with no bus traffic.
- R3: Read data is right-aligned and zero-extended. Lanes are big-endian: byte offset 0 is bits 31:24 of a word, and a halfword at offset 0 is bits 31:16.
- R4: Store byte enables follow the big-endian lanes, with enable bit 3 for offset 0. A byte at offset k gives 1000 shifted right by k. A halfword gives 1100 at offset 0 and 0011 at offset 2. A word gives 1111. Store data is replicated across the lanes.
- R5: In write-back mode, a store hit updates only the cache and issues no bus access. The line becomes dirty.
- R6: In write-back mode, a store miss fills the line with four reads and merges the store into it. Memory keeps its old value until the line is evicted.
- R7: When a miss replaces a dirty line, the four reads of the fill come first. They are followed by four writes of the saved old line to its own address. A clean victim causes no writes.
- R8: In write-through mode, a store hit updates the cache and issues one bus write with the store's enables. A later read hit returns the new data.
- R9: In write-through mode, a store miss issues one bus write and no reads, and does not allocate. A later read of that address misses, and a line already cached at that index is not disturbed.
- R10: An address with bit 15 set is non-cacheable. It becomes one bus access at the actual address, with the enables of its size, and leaves the cache untouched.
- R11: An instruction fetch takes its size from the address: offset 0 is a word fetch (enables 1111) and offset 2 is a halfword fetch (enables 0011). The size input is ignored for fetches.
- R12: After reset, every line is invalid and clean, and `bus_req` and `cpu_ready` are low.
- R13: While `bus_req` is high and `bus_ack` has not arrived, the bus address, direction, enables and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_mode | input | 1 | 1 selects write-back, 0 selects write-through |
| cpu_req | input | 1 | Request, held until cpu_ready |
| cpu_we | input | 1 | Store when 1 |
| cpu_ifetch | input | 1 | Instruction fetch (read, size from address) |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | AW | Byte address; top bit marks non-cacheable |
| cpu_wdata | input | 32 | Store data, right-aligned |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, right-aligned, valid with cpu_ready |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | Bus write when 1 |
| bus_addr | output | AW | Bus byte address |
| bus_be | output | 4 | Byte enables, bit 3 = byte offset 0 |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| bus_ack | input | 1 | Beat acknowledge |

## Verification
Reads are swept over every offset and size of a cached line. This separates lane selection from the hit path. Stores of each size at every offset, in write-through mode, expose the enable pattern on the bus. Misses are driven against invalid, clean and dirty victims, in both policies. The order and addresses of the bus beats show whether the fill came before the eviction and whether a store allocated. Non-cacheable reads, stores and fetches at offsets 0 and 2 show that the requested size reaches the bus unchanged, and that the cache is bypassed.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_UNC,
        ST_FILL,
        ST_FIN,
        ST_WBACK,
        ST_WT,
        ST_DONE
    } state_e;

    // fetches ignore the size input: bit 1 of the address picks half or word
    function automatic size_e eff_size(logic ifetch, size_e sz, logic [1:0] off);
        if (ifetch) return off[1] ? SZ_HALF : SZ_WORD;
        return sz;
    endfunction

    // enable bit 3 covers byte offset 0 (bits 31:24)
    function automatic logic [3:0] lane_be(size_e sz, logic [1:0] off);
        case (sz)
            SZ_BYTE: begin
                case (off)
                    2'd0:    return 4'b1000;
                    2'd1:    return 4'b0100;
                    2'd2:    return 4'b0010;
                    default: return 4'b0001;
                endcase
            end
            SZ_HALF: return off[1] ? 4'b0011 : 4'b1100;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] lane_wdata(size_e sz, logic [31:0] d);
        case (sz)
            SZ_BYTE: return {4{d[7:0]}};
            SZ_HALF: return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] lane_rdata(size_e sz, logic [1:0] off, logic [31:0] w);
        case (sz)
            SZ_BYTE: begin
                case (off)
                    2'd0:    return {24'd0, w[31:24]};
                    2'd1:    return {24'd0, w[23:16]};
                    2'd2:    return {24'd0, w[15:8]};
                    default: return {24'd0, w[7:0]};
                endcase
            end
            SZ_HALF: return off[1] ? {16'd0, w[15:0]} : {16'd0, w[31:16]};
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] word_of(logic [127:0] line, logic [1:0] sel);
        case (sel)
            2'd0:    return line[31:0];
            2'd1:    return line[63:32];
            2'd2:    return line[95:64];
            default: return line[127:96];
        endcase
    endfunction

endpackage

// File: rtl/wpc_lanes.sv
module wpc_lanes
    import wpc_pkg::*;
(
    input  size_e       sz,
    input  logic [1:0]  off,
    input  logic [31:0] wdata,
    input  logic [31:0] rword,
    output logic [3:0]  be,
    output logic [31:0] wlane,
    output logic [31:0] rdata
);
    assign be    = lane_be(sz, off);
    assign wlane = lane_wdata(sz, wdata);
    assign rdata = lane_rdata(sz, off, rword);
endmodule

// File: rtl/wpc_store.sv
module wpc_store #(
    parameter int LINES = 4,
    parameter int IDXW  = 2,
    parameter int TAGW  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [127:0]     rd_line,
    output logic [TAGW-1:0]  rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [1:0]       wr_word,
    input  logic [3:0]       wr_be,
    input  logic [31:0]      wr_data,
    input  logic             meta_en,
    input  logic [IDXW-1:0]  meta_idx,
    input  logic [TAGW-1:0]  meta_tag,
    input  logic             meta_valid,
    input  logic             meta_dirty
);
    logic [31:0]     data_q [LINES][4];
    logic [TAGW-1:0] tag_q  [LINES];
    logic [LINES-1:0] valid_q, dirty_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (wr_be[k]) data_q[wr_idx][wr_word][8*k +: 8] <= wr_data[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (meta_en) begin
            tag_q[meta_idx]   <= meta_tag;
            valid_q[meta_idx] <= meta_valid;
            dirty_q[meta_idx] <= meta_dirty;
        end
    end

    for (genvar w = 0; w < 4; w++) begin : g_rd
        assign rd_line[32*w +: 32] = data_q[rd_idx][w];
    end
    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    // R12: a line can only be dirty while it is valid
    a_r12_dirty_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
    import wpc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LINES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wb_mode,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_ifetch,
    input  logic [1:0]    cpu_size,
    input  logic [AW-1:0] cpu_addr,
    input  logic [31:0]   cpu_wdata,
    output logic          cpu_ready,
    output logic [31:0]   cpu_rdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [3:0]    bus_be,
    output logic [31:0]   bus_wdata,
    input  logic [31:0]   bus_rdata,
    input  logic          bus_ack
);
    localparam int IDXW = $clog2(LINES);
    localparam int TAGW = AW - IDXW - 4;
    localparam int NCB  = AW - 1;

    state_e          st, nxt;
    logic [AW-1:0]   a_q;
    logic            we_q, wb_q;
    size_e           sz_q;
    logic [31:0]     wd_q, rdata_q;
    logic [1:0]      beat;
    logic [127:0]    v_line;
    logic [TAGW-1:0] v_tag;
    logic            v_dirty;

    logic [TAGW-1:0] a_tag;
    logic [IDXW-1:0] a_idx;
    assign a_tag = a_q[AW-1 -: TAGW];
    assign a_idx = a_q[4 +: IDXW];

    logic [127:0]    rd_line;
    logic [TAGW-1:0] rd_tag;
    logic            rd_valid, rd_dirty, hit;
    logic            wr_en, meta_en, meta_dirty;
    logic [1:0]      wr_word;
    logic [3:0]      wr_be, l_be;
    logic [31:0]     wr_data, l_wdata, l_rdata, r_src;
    logic            load_rd, start_miss, beat_inc;

    assign hit = rd_valid && (rd_tag == a_tag);

    wpc_store #(.LINES(LINES), .IDXW(IDXW), .TAGW(TAGW)) u_store (
        .clk(clk), .rst(rst),
        .rd_idx(a_idx), .rd_line(rd_line), .rd_tag(rd_tag),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .wr_en(wr_en), .wr_idx(a_idx), .wr_word(wr_word), .wr_be(wr_be), .wr_data(wr_data),
        .meta_en(meta_en), .meta_idx(a_idx), .meta_tag(a_tag),
        .meta_valid(1'b1), .meta_dirty(meta_dirty)
    );

    assign r_src = (st == ST_UNC) ? bus_rdata : word_of(rd_line, a_q[3:2]);

    wpc_lanes u_lanes (
        .sz(sz_q), .off(a_q[1:0]), .wdata(wd_q), .rword(r_src),
        .be(l_be), .wlane(l_wdata), .rdata(l_rdata)
    );

    always_comb begin
        nxt        = st;
        bus_req    = 1'b0;
        bus_we     = 1'b0;
        bus_addr   = '0;
        bus_be     = 4'b0000;
        bus_wdata  = '0;
        wr_en      = 1'b0;
        wr_word    = a_q[3:2];
        wr_be      = l_be;
        wr_data    = l_wdata;
        meta_en    = 1'b0;
        meta_dirty = 1'b0;
        load_rd    = 1'b0;
        start_miss = 1'b0;
        beat_inc   = 1'b0;
        case (st)
            ST_IDLE: if (cpu_req) nxt = ST_LOOK;
            ST_LOOK: begin
                if (a_q[NCB]) begin
                    nxt = ST_UNC;
                end else if (!we_q) begin
                    if (hit) begin load_rd = 1'b1; nxt = ST_DONE; end
                    else     begin start_miss = 1'b1; nxt = ST_FILL; end
                end else if (wb_q) begin
                    if (hit) begin
                        wr_en = 1'b1; meta_en = 1'b1; meta_dirty = 1'b1; nxt = ST_DONE;
                    end else begin
                        start_miss = 1'b1; nxt = ST_FILL;
                    end
                end else begin
                    wr_en = hit;
                    nxt   = ST_WT;
                end
            end
            ST_FILL: begin
                bus_req  = 1'b1;
                bus_addr = {a_tag, a_idx, beat, 2'b00};
                bus_be   = 4'b1111;
                if (bus_ack) begin
                    wr_en    = 1'b1;
                    wr_word  = beat;
                    wr_be    = 4'b1111;
                    wr_data  = bus_rdata;
                    beat_inc = 1'b1;
                    if (beat == 2'd3) nxt = ST_FIN;
                end
            end
            ST_FIN: begin
                wr_en      = we_q;
                meta_en    = 1'b1;
                meta_dirty = we_q;
                load_rd    = 1'b1;
                nxt        = v_dirty ? ST_WBACK : ST_DONE;
            end
            ST_WBACK: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = {v_tag, a_idx, beat, 2'b00};
                bus_be    = 4'b1111;
                bus_wdata = word_of(v_line, beat);
                if (bus_ack) begin
                    beat_inc = 1'b1;
                    if (beat == 2'd3) nxt = ST_DONE;
                end
            end
            ST_WT: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = a_q;
                bus_be    = l_be;
                bus_wdata = l_wdata;
                if (bus_ack) nxt = ST_DONE;
            end
            ST_UNC: begin
                bus_req   = 1'b1;
                bus_we    = we_q;
                bus_addr  = a_q;
                bus_be    = l_be;
                bus_wdata = l_wdata;
                if (bus_ack) begin load_rd = !we_q; nxt = ST_DONE; end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            beat    <= 2'd0;
            v_dirty <= 1'b0;
            rdata_q <= '0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && cpu_req) begin
                a_q  <= cpu_addr;
                we_q <= cpu_we && !cpu_ifetch;
                wb_q <= wb_mode;
                sz_q <= eff_size(cpu_ifetch, size_e'(cpu_size), cpu_addr[1:0]);
                wd_q <= cpu_wdata;
            end
            if (start_miss) begin
                v_line  <= rd_line;
                v_tag   <= rd_tag;
                v_dirty <= rd_valid && rd_dirty;
                beat    <= 2'd0;
            end else if (beat_inc) begin
                beat <= beat + 2'd1;
            end
            if (load_rd) rdata_q <= l_rdata;
        end
    end

    assign cpu_ready = (st == ST_DONE);
    assign cpu_rdata = rdata_q;

    a_r2_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    a_r13_bus_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_be) && $stable(bus_wdata)));

    a_r1_fill_step: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FILL && bus_ack && beat != 2'd3) |=> (bus_addr == $past(bus_addr) + AW'(4)));

    a_r7_fill_before_evict: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WBACK && $past(st) != ST_WBACK) |-> $past(st) == ST_FIN);

    a_r5_dirty_only_wb: assert property (@(posedge clk) disable iff (rst)
        (meta_en && meta_dirty) |-> (wb_q && we_q));

    a_r10_unc_single: assert property (@(posedge clk) disable iff (rst)
        (st == ST_UNC && bus_ack) |=> !bus_req);
endmodule

// File: tb/wpc_cache_tb.sv
`timescale 1ns/1ps
module wpc_cache_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_mode = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_ifetch = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack;

    always #2.5 clk = ~clk;

    wpc_cache u_dut (
        .clk(clk), .rst(rst), .wb_mode(wb_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ifetch(cpu_ifetch), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int checks = 0;
    int fails  = 0;

    function automatic logic [31:0] initval(int i);
        logic [7:0] b;
        b = i[7:0];
        return {b ^ 8'h3C, i[11:4], b ^ 8'hC3, b + 8'd1};
    endfunction

    // bus slave memory, op log and hold monitor
    logic [31:0] mem  [4096];
    logic [31:0] gold [4096];
    logic [15:0] log_addr [64];
    logic        log_we   [64];
    logic [3:0]  log_be   [64];
    int          log_n = 0;
    logic        pend = 1'b0, hold_err = 1'b0;
    logic [15:0] pa;
    logic        pw;

    always @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            pend      <= 1'b0;
            for (int i = 0; i < 4096; i++) mem[i] <= initval(i);
        end else begin
            if (pend && (!bus_req || bus_addr != pa || bus_we != pw)) hold_err <= 1'b1;
            pend <= bus_req && !bus_ack;
            pa   <= bus_addr;
            pw   <= bus_we;
            if (bus_req && !bus_ack) begin
                bus_ack <= 1'b1;
                log_addr[log_n % 64] <= bus_addr;
                log_we[log_n % 64]   <= bus_we;
                log_be[log_n % 64]   <= bus_be;
                log_n <= log_n + 1;
                if (bus_we) begin
                    for (int k = 0; k < 4; k++)
                        if (bus_be[k]) mem[bus_addr[13:2]][8*k +: 8] <= bus_wdata[8*k +: 8];
                end else begin
                    bus_rdata <= mem[bus_addr[13:2]];
                end
            end else begin
                bus_ack <= 1'b0;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(int sz, int off);
        if (sz == 0) return 4'(1 << (3 - off));
        if (sz == 1) return (off < 2) ? 4'hC : 4'h3;
        return 4'hF;
    endfunction

    function automatic int eff(logic ifet, int sz, int off);
        if (ifet) return (off >= 2) ? 1 : 2;
        return sz;
    endfunction

    function automatic logic [31:0] exp_rd(logic ifet, int sz, logic [15:0] a);
        logic [31:0] w;
        int s, off;
        w = gold[a[13:2]];
        off = int'(a[1:0]);
        s = eff(ifet, sz, off);
        if (s == 0) return (w >> (8 * (3 - off))) & 32'hFF;
        if (s == 1) return (off < 2) ? (w >> 16) : (w & 32'hFFFF);
        return w;
    endfunction

    task automatic gold_write(input int sz, input logic [15:0] a, input logic [31:0] d);
        logic [3:0]  be;
        logic [31:0] rep;
        be  = exp_be(sz, int'(a[1:0]));
        rep = (sz == 0) ? {4{d[7:0]}} : (sz == 1) ? {2{d[15:0]}} : d;
        for (int k = 0; k < 4; k++)
            if (be[k]) gold[a[13:2]][8*k +: 8] = rep[8*k +: 8];
    endtask

    int s_n;
    task automatic access(input logic we, input logic ifet, input int sz, input logic [15:0] a,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int nrd, output int nwr);
        int n;
        @(negedge clk);
        cpu_we = we; cpu_ifetch = ifet; cpu_size = 2'(sz); cpu_addr = a; cpu_wdata = wd;
        cpu_req = 1'b1;
        s_n = log_n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ready && n < 300);
        if (!cpu_ready) chk(1'b0, "R2 timeout", 32'(n), 32'd0);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        if (we && !ifet) gold_write(sz, a, wd);
        nrd = 0; nwr = 0;
        for (int i = s_n; i < log_n; i++) if (log_we[i % 64]) nwr++; else nrd++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int nr, nw;
        bit ok;
        for (int i = 0; i < 4096; i++) gold[i] = initval(i);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!cpu_ready && !bus_req, "R12 reset outputs", {30'd0, cpu_ready, bus_req}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1/R12: first access misses, four reads in line order
        access(0, 0, 0, 16'h0013, 0, rd, nr, nw);
        chk(nr == 4 && nw == 0, "R1 R12 fill beat count", 32'(nr*16+nw), 32'd64);
        ok = 1;
        for (int k = 0; k < 4; k++)
            if (log_addr[(s_n+k)%64] != 16'h0010 + 16'(4*k) || log_be[(s_n+k)%64] != 4'hF) ok = 0;
        chk(ok, "R1 fill addresses", {16'd0, log_addr[s_n%64]}, 32'h10);
        chk(rd == exp_rd(0, 0, 16'h0013), "R3 byte after fill", rd, exp_rd(0, 0, 16'h0013));
        @(negedge clk);
        chk(!cpu_ready, "R2 ready single pulse", {31'd0, cpu_ready}, 32'd0);

        // R2/R3: hit sweep over every offset and size
        for (int off = 0; off < 16; off++) begin
            for (int sz = 0; sz < 3; sz++) begin
                if ((sz == 1 && off % 2 != 0) || (sz == 2 && off % 4 != 0)) continue;
                access(0, 0, sz, 16'h0010 + 16'(off), 0, rd, nr, nw);
                chk(nr + nw == 0, "R2 read hit no bus", 32'(nr+nw), 32'd0);
                chk(rd == exp_rd(0, sz, 16'h0010 + 16'(off)), "R3 lane data", rd,
                    exp_rd(0, sz, 16'h0010 + 16'(off)));
            end
        end

        // R11 cached fetch at offset 2 returns halfword
        access(0, 1, 0, 16'h0012, 0, rd, nr, nw);
        chk(rd == exp_rd(1, 0, 16'h0012), "R11 cached fetch half", rd, exp_rd(1, 0, 16'h0012));

        // R5 write-back hit
        wb_mode = 1'b1;
        access(1, 0, 0, 16'h0011, 32'h5A, rd, nr, nw);
        chk(nr + nw == 0, "R5 wb hit no bus", 32'(nr+nw), 32'd0);
        chk(mem[4] == initval(4), "R5 memory untouched", mem[4], initval(4));
        access(0, 0, 2, 16'h0010, 0, rd, nr, nw);
        chk(rd == gold[4], "R5 cache holds store", rd, gold[4]);

        // R4/R8 write-through hits: every size and offset
        wb_mode = 1'b0;
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 4; off++) begin
                if ((sz == 1 && off % 2 != 0) || (sz == 2 && off != 0)) continue;
                access(1, 0, sz, 16'h0014 + 16'(off), 32'hC0DE0000 + 32'(sz*16+off+1), rd, nr, nw);
                chk(nr == 0 && nw == 1, "R8 wt hit one write", 32'(nr*16+nw), 32'd1);
                chk(log_be[s_n%64] == exp_be(sz, off), "R4 byte enables",
                    {28'd0, log_be[s_n%64]}, {28'd0, exp_be(sz, off)});
                chk(mem[5] == gold[5], "R8 memory written", mem[5], gold[5]);
                access(0, 0, 2, 16'h0014, 0, rd, nr, nw);
                chk(rd == gold[5] && nr + nw == 0, "R8 cache updated", rd, gold[5]);
            end
        end

        // R7 read miss evicting dirty line 0x10
        wb_mode = 1'b1;
        access(0, 0, 2, 16'h0058, 0, rd, nr, nw);
        chk(nr == 4 && nw == 4, "R7 fill and evict counts", 32'(nr*16+nw), 32'h44);
        ok = 1;
        for (int k = 0; k < 8; k++) begin
            if (log_we[(s_n+k)%64] != (k >= 4)) ok = 0;
            if (k >= 4 && log_addr[(s_n+k)%64] != 16'h0010 + 16'(4*(k-4))) ok = 0;
        end
        chk(ok, "R7 reads then victim writes", 32'(ok), 32'd1);
        chk(mem[4] == gold[4] && mem[5] == gold[5], "R7 victim data in memory", mem[4], gold[4]);
        chk(rd == gold[16'h58 >> 2], "R3 word after evict fill", rd, gold[16'h58 >> 2]);

        // R6 write-back miss, clean victim
        access(1, 0, 2, 16'h0020, 32'hDEADBEEF, rd, nr, nw);
        chk(nr == 4 && nw == 0, "R6 wb miss fills only", 32'(nr*16+nw), 32'h40);
        chk(mem[8] == initval(8), "R6 memory keeps old", mem[8], initval(8));
        access(0, 0, 2, 16'h0020, 0, rd, nr, nw);
        chk(rd == 32'hDEADBEEF && nr + nw == 0, "R6 merged store hit", rd, 32'hDEADBEEF);

        // R6/R7 write-back miss, dirty victim
        access(1, 0, 1, 16'h00A2, 32'h1234, rd, nr, nw);
        chk(nr == 4 && nw == 4 && !log_we[s_n%64] && log_we[(s_n+7)%64],
            "R7 wb miss fill before evict", 32'(nr*16+nw), 32'h44);
        chk(mem[8] == 32'hDEADBEEF, "R7 evicted store", mem[8], 32'hDEADBEEF);
        access(0, 0, 2, 16'h00A0, 0, rd, nr, nw);
        chk(rd == gold[16'hA0 >> 2] && nr + nw == 0, "R6 merge into filled line", rd, gold[16'hA0 >> 2]);

        // R9 write-through misses
        wb_mode = 1'b0;
        access(1, 0, 2, 16'h0130, 32'h0BADF00D, rd, nr, nw);
        chk(nr == 0 && nw == 1, "R9 wt miss single write", 32'(nr*16+nw), 32'd1);
        chk(mem[16'h130 >> 2] == 32'h0BADF00D, "R9 memory written", mem[16'h130 >> 2], 32'h0BADF00D);
        access(0, 0, 2, 16'h0130, 0, rd, nr, nw);
        chk(nr == 4 && rd == 32'h0BADF00D, "R9 no allocation", 32'(nr), 32'd4);
        access(1, 0, 0, 16'h0171, 32'h77, rd, nr, nw);
        chk(nr == 0 && nw == 1, "R9 wt miss other tag", 32'(nr*16+nw), 32'd1);
        access(0, 0, 2, 16'h0130, 0, rd, nr, nw);
        chk(nr + nw == 0 && rd == 32'h0BADF00D, "R9 resident line intact", rd, 32'h0BADF00D);

        // R10 non-cacheable accesses
        wb_mode = 1'b1;
        access(0, 0, 0, 16'h8405, 0, rd, nr, nw);
        chk(nr == 1 && nw == 0 && log_be[s_n%64] == 4'b0100, "R10 uncached byte read",
            {28'd0, log_be[s_n%64]}, 32'h4);
        chk(rd == exp_rd(0, 0, 16'h8405) && log_addr[s_n%64] == 16'h8405, "R10 actual address data",
            rd, exp_rd(0, 0, 16'h8405));
        access(1, 0, 1, 16'h8406, 32'hBEEF, rd, nr, nw);
        chk(nr == 0 && nw == 1 && log_be[s_n%64] == 4'b0011, "R10 uncached half write",
            {28'd0, log_be[s_n%64]}, 32'h3);
        chk(mem[16'h8406 >> 2 & 16'hFFF] == gold[16'h8406 >> 2 & 16'hFFF], "R10 memory written",
            mem[16'h8406 >> 2 & 16'hFFF], gold[16'h8406 >> 2 & 16'hFFF]);
        access(0, 0, 2, 16'h8404, 0, rd, nr, nw);
        chk(nr == 1 && rd == exp_rd(0, 2, 16'h8404), "R10 not cached", rd, exp_rd(0, 2, 16'h8404));

        // R11 non-cacheable fetches
        access(0, 1, 0, 16'h8408, 0, rd, nr, nw);
        chk(nr == 1 && log_be[s_n%64] == 4'hF && rd == exp_rd(1, 0, 16'h8408), "R11 fetch word",
            rd, exp_rd(1, 0, 16'h8408));
        access(0, 1, 0, 16'h840A, 0, rd, nr, nw);
        chk(nr == 1 && log_be[s_n%64] == 4'h3 && rd == exp_rd(1, 0, 16'h840A), "R11 fetch half",
            rd, exp_rd(1, 0, 16'h840A));

        chk(!hold_err, "R13 bus held until ack", {31'd0, hold_err}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule